// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

This block sits between a processor port that issues byte loads and byte stores on a 12-bit byte address and a memory port that moves whole 4-byte blocks. It keeps four entries, one block each, for 16 bytes of data. Every address has exactly one candidate entry: the low two bits pick a byte inside the block, the next two bits pick the entry, and the upper eight bits are kept as the tag that tells which block occupies that entry.

Stores use a write-back, write-allocate policy. A store that misses first brings the block in and then merges the byte, so the entry becomes dirty. When a miss lands on an entry holding a modified block, that block goes back to memory at the address rebuilt from its stored tag and the entry number before the new block is requested. Hits are served without any memory traffic. While a miss is in progress the processor request port is held off, and each memory transfer waits for its ready/valid handshake.

Top module: `dmc_cache`

## Requirements
- R1: After reset every entry is invalid and clean; the processor port is ready, no memory request is raised and no response is pending, so the first access to any address misses.
- R2: Address bits 11:4 form the tag, bits 3:2 the entry number and bits 1:0 the byte offset; every memory request carries a block-aligned address (bits 1:0 zero), and byte k of a block occupies bits 8k+7:8k of the memory data word.
- R3: A hit requires the addressed entry to be valid and its stored tag to equal the address tag; a load hit raises the response in the cycle right after the accepting edge, with no memory request.
- R4: A store hit replaces only the addressed byte, marks the entry dirty and makes no memory request; later loads of that byte return the stored value.
- R5: A miss on an entry that is invalid or clean issues exactly one block read at the request's block address and no write; the block is installed valid and clean, and a load returns the byte selected by the offset.
- R6: A store miss allocates the block as a load miss does, then writes the addressed byte and marks the entry dirty.
- R7: A miss on a valid dirty entry first writes the old block, with its current contents, to the address built from its stored tag and the entry number; the block read follows only after that write handshake has completed.
- R8: The processor ready output is low whenever a miss is being serviced, and a raised memory request keeps its address and direction stable until the memory accepts it.
- R9: Every accepted request yields exactly one response pulse, delivered while the processor port is ready again; a store's response echoes the stored byte.
- R10: Two blocks that share an entry number but differ in tag evict each other, even while other entries are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = byte store, 0 = byte load |
| cpu_req_addr | input | 12 | Byte address |
| cpu_req_wdata | input | 8 | Store data |
| cpu_req_ready | output | 1 | Request accepted on this edge when valid |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | 8 | Loaded byte, or the stored byte for a store |
| mem_req_valid | output | 1 | Block transfer requested |
| mem_req_write | output | 1 | 1 = block write-back, 0 = block read |
| mem_req_addr | output | 12 | Block-aligned memory address |
| mem_req_wdata | output | 32 | Block being written back |
| mem_req_ready | input | 1 | Memory completes the transfer on this edge |
| mem_rdata | input | 32 | Block read data, valid with mem_req_ready |

## Verification
The in-design properties watch, cycle by cycle, that memory requests stay aligned and stable until taken, that a write-back is always followed by a read, that a fill leaves its entry valid and clean, that a byte store leaves it dirty, and that a hit answers on the next cycle without touching memory. Whether the returned bytes are right, whether the victim written back carries every earlier store, whether tag comparison picks hit or miss correctly, and how conflicting blocks evict each other only show up in the bench's access sequences, checked against a reference memory and a shadow of the entry state.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_RESP  = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]  off
);
  assign tag = addr[ADDR_W-1 -: TAG_W];
  assign idx = addr[OFF_W +: IDX_W];
  assign off = addr[OFF_W-1:0];
endmodule

// File: rtl/dmc_store.sv
module dmc_store #(
  parameter int NUM_SETS    = 4,
  parameter int BLOCK_BYTES = 4,
  parameter int TAG_W       = 8,
  localparam int IDX_W = $clog2(NUM_SETS),
  localparam int OFF_W = $clog2(BLOCK_BYTES),
  localparam int BLK_W = 8 * BLOCK_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  output logic [BLK_W-1:0] rd_block,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [BLK_W-1:0] fill_block,
  input  logic             byte_we,
  input  logic [OFF_W-1:0] byte_off,
  input  logic [7:0]       byte_data
);
  logic [NUM_SETS-1:0] valid_vec;
  logic [NUM_SETS-1:0] dirty_vec;
  logic [TAG_W-1:0]    tag_arr [NUM_SETS];
  logic [BLK_W-1:0]    blk_arr [NUM_SETS];

  for (genvar e = 0; e < NUM_SETS; e++) begin : g_entry
    logic             v_q, d_q;
    logic [TAG_W-1:0] t_q;
    logic [BLK_W-1:0] b_q, b_d;
    logic             sel, fill_hit, wr_hit, blk_en;

    assign sel      = (idx == IDX_W'(e));
    assign fill_hit = fill_en & sel;
    assign wr_hit   = byte_we & sel;
    assign blk_en   = fill_hit | wr_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (fill_hit) begin
        v_q <= 1'b1;
        d_q <= 1'b0;
      end else if (wr_hit) begin
        d_q <= 1'b1;
      end
    end

    always_comb begin
      b_d = b_q;
      if (fill_hit) b_d = fill_block;
      else if (wr_hit) b_d[byte_off*8 +: 8] = byte_data;
    end

    always_ff @(posedge clk) begin
      if (fill_hit) t_q <= fill_tag;
      if (blk_en)   b_q <= b_d;
    end

    assign valid_vec[e] = v_q;
    assign dirty_vec[e] = d_q;
    assign tag_arr[e]   = t_q;
    assign blk_arr[e]   = b_q;
  end

  assign rd_valid = valid_vec[idx];
  assign rd_dirty = dirty_vec[idx];
  assign rd_tag   = tag_arr[idx];
  assign rd_block = blk_arr[idx];

  // R5: an installed block is valid and clean
  assert_fill_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_vec[$past(idx)] && !dirty_vec[$past(idx)]));

  // R6 / R4: a byte store leaves its entry dirty
  assert_store_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |=> (valid_vec[$past(idx)] && dirty_vec[$past(idx)]));
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req_valid,
  input  logic       hit,
  input  logic       victim_dirty,
  input  logic       mem_req_ready,
  output dmc_state_e state,
  output logic       cpu_req_ready,
  output logic       capture,
  output logic       hit_access,
  output logic       resp_access,
  output logic       mem_req_valid,
  output logic       mem_req_write,
  output logic       fill_en
);
  dmc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cpu_req_valid && !hit) state_d = victim_dirty ? ST_WBACK : ST_FILL;
      ST_WBACK: if (mem_req_ready) state_d = ST_FILL;
      ST_FILL:  if (mem_req_ready) state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state         = state_q;
  assign cpu_req_ready = (state_q == ST_IDLE);
  assign capture       = cpu_req_ready & cpu_req_valid & ~hit;
  assign hit_access    = cpu_req_ready & cpu_req_valid & hit;
  assign resp_access   = (state_q == ST_RESP);
  assign mem_req_valid = (state_q == ST_WBACK) | (state_q == ST_FILL);
  assign mem_req_write = (state_q == ST_WBACK);
  assign fill_en       = (state_q == ST_FILL) & mem_req_ready;

  // R7: a completed write-back is followed at once by a block read
  assert_wb_then_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_req_ready) |=> (mem_req_valid && !mem_req_write));

  // R8: a pending request holds its direction until accepted
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_write)));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_SETS    = 4,
  parameter int BLOCK_BYTES = 4,
  localparam int IDX_W = $clog2(NUM_SETS),
  localparam int OFF_W = $clog2(BLOCK_BYTES),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int BLK_W = 8 * BLOCK_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [7:0]        cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_rsp_valid,
  output logic [7:0]        cpu_rsp_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BLK_W-1:0]  mem_req_wdata,
  input  logic              mem_req_ready,
  input  logic [BLK_W-1:0]  mem_rdata
);
  dmc_state_e        state;
  logic              capture, hit_access, resp_access, fill_en;
  logic              hit, victim_dirty;
  logic              q_write;
  logic [ADDR_W-1:0] q_addr;
  logic [7:0]        q_wdata;
  logic [ADDR_W-1:0] look_addr;
  logic [TAG_W-1:0]  look_tag, st_tag;
  logic [IDX_W-1:0]  look_idx;
  logic [OFF_W-1:0]  look_off;
  logic              st_valid, st_dirty;
  logic [BLK_W-1:0]  st_block;
  logic              do_access, acc_write;
  logic [7:0]        acc_wdata, rsp_d;
  logic              rsp_valid_q;
  logic [7:0]        rsp_rdata_q;

  // Live request in IDLE, captured request while a miss is serviced
  assign look_addr = cpu_req_ready ? cpu_req_addr  : q_addr;
  assign acc_write = cpu_req_ready ? cpu_req_write : q_write;
  assign acc_wdata = cpu_req_ready ? cpu_req_wdata : q_wdata;

  dmc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .addr (look_addr),
    .tag  (look_tag),
    .idx  (look_idx),
    .off  (look_off)
  );

  dmc_store #(.NUM_SETS(NUM_SETS), .BLOCK_BYTES(BLOCK_BYTES), .TAG_W(TAG_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (look_idx),
    .rd_valid   (st_valid),
    .rd_dirty   (st_dirty),
    .rd_tag     (st_tag),
    .rd_block   (st_block),
    .fill_en    (fill_en),
    .fill_tag   (look_tag),
    .fill_block (mem_rdata),
    .byte_we    (do_access & acc_write),
    .byte_off   (look_off),
    .byte_data  (acc_wdata)
  );

  assign hit          = st_valid & (st_tag == look_tag);
  assign victim_dirty = st_valid & st_dirty;

  dmc_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .hit           (hit),
    .victim_dirty  (victim_dirty),
    .mem_req_ready (mem_req_ready),
    .state         (state),
    .cpu_req_ready (cpu_req_ready),
    .capture       (capture),
    .hit_access    (hit_access),
    .resp_access   (resp_access),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .fill_en       (fill_en)
  );

  always_ff @(posedge clk) begin
    if (capture) begin
      q_addr  <= cpu_req_addr;
      q_write <= cpu_req_write;
      q_wdata <= cpu_req_wdata;
    end
  end

  // Write-back goes to the victim's address; a fill to the request's block
  assign mem_req_addr  = (state == ST_WBACK) ? {st_tag, look_idx, {OFF_W{1'b0}}}
                                             : {look_tag, look_idx, {OFF_W{1'b0}}};
  assign mem_req_wdata = st_block;

  assign do_access = hit_access | resp_access;
  assign rsp_d     = acc_write ? acc_wdata : st_block[look_off*8 +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= 1'b0;
    else        rsp_valid_q <= do_access;
  end

  always_ff @(posedge clk) begin
    if (do_access) rsp_rdata_q <= rsp_d;
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_rdata_q;

  // R2: memory only sees block-aligned addresses
  assert_block_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

  // R3: a hit answers next cycle without any memory request
  assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && hit) |=> (cpu_rsp_valid && !mem_req_valid));

  // R8: request address held until memory accepts
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

  // R8: processor port closed while memory is busy
  assert_busy_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cpu_req_ready);

  // R9: a response arrives only once the port is open again
  assert_rsp_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> cpu_req_ready);
endmodule

// File: tb/tb_dmc_cache.sv
module tb_dmc_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_write = 1'b0;
  logic [11:0] cpu_req_addr = '0;
  logic [7:0]  cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [7:0]  cpu_rsp_rdata;
  logic        mem_req_valid, mem_req_write;
  logic [11:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rdy = 1'b0;
  logic [31:0] mem_rdata;

  always #2.5 clk = ~clk;

  dmc_cache dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_req_ready(mem_rdy), .mem_rdata(mem_rdata)
  );

  int vecs = 0, errs = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference memory (truth as the processor sees it) and backing memory
  logic [7:0]  gm  [4096];
  logic [31:0] mem [1024];
  function automatic logic [7:0] seed(input int a);
    return 8'(a) ^ {4'(a >> 8), 4'(a >> 8)} ^ 8'h5A;
  endfunction
  function automatic logic [31:0] gword(input logic [11:0] a);
    return {gm[{a[11:2], 2'd3}], gm[{a[11:2], 2'd2}], gm[{a[11:2], 2'd1}], gm[{a[11:2], 2'd0}]};
  endfunction
  initial begin
    for (int i = 0; i < 4096; i++) gm[i] = seed(i);
    for (int w = 0; w < 1024; w++)
      mem[w] = {seed(4*w+3), seed(4*w+2), seed(4*w+1), seed(4*w)};
  end
  assign mem_rdata = mem[mem_req_addr[11:2]];

  // Memory responder
  int n_rd = 0, n_wr = 0, wcnt = 0, rd_cyc = 0, wr_cyc = 0;
  logic [11:0] rd_addr = '0, wb_addr = '0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_req_valid && mem_rdy) begin
      if (mem_req_write) begin
        chk(mem_req_wdata == gword(mem_req_addr), "R7", "write-back data",
            int'(mem_req_wdata), int'(gword(mem_req_addr)));
        mem[mem_req_addr[11:2]] <= mem_req_wdata;
        n_wr <= n_wr + 1; wb_addr <= mem_req_addr; wr_cyc <= cyc;
      end else begin
        n_rd <= n_rd + 1; rd_addr <= mem_req_addr; rd_cyc <= cyc;
      end
    end
  end
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rdy = 1'b0; wcnt = 0;
    end else if (mem_rdy) begin
      mem_rdy = 1'b0; wcnt = 0;
    end else if (mem_req_valid) begin
      if (wcnt >= (n_rd + n_wr) % 3) mem_rdy = 1'b1;
      else wcnt++;
    end
  end

  // Scoreboard monitor
  logic [7:0] expq [$];
  int rsp_cnt = 0, rsp_cyc = 0;
  always @(negedge clk) begin
    if (rst_n && cpu_rsp_valid) begin
      if (expq.size() == 0) chk(1'b0, "R9", "unexpected response", 1, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(cpu_rsp_rdata == e, "R9", "response byte", int'(cpu_rsp_rdata), int'(e));
      end
      rsp_cnt = rsp_cnt + 1;
      rsp_cyc = cyc;
    end
  end

  // Shadow of entry state
  bit         mv [4];
  bit         md [4];
  logic [7:0] mt [4];

  task automatic access(input bit wr, input logic [11:0] a, input logic [7:0] d,
                        input string req);
    logic [1:0] ix;
    bit hit, ewb;
    int rd0, wr0, rc0, acc;
    logic [11:0] vict;
    ix   = a[3:2];
    hit  = mv[ix] && (mt[ix] == a[11:4]);
    ewb  = !hit && mv[ix] && md[ix];
    vict = {mt[ix], ix, 2'b00};
    if (wr) begin
      gm[a] = d;
      expq.push_back(d);
    end else expq.push_back(gm[a]);
    if (!hit) begin mv[ix] = 1'b1; mt[ix] = a[11:4]; md[ix] = 1'b0; end
    if (wr) md[ix] = 1'b1;
    rd0 = n_rd; wr0 = n_wr; rc0 = rsp_cnt;
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
    while (!cpu_req_ready) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    wait (rsp_cnt != rc0);
    chk(n_rd - rd0 == (hit ? 0 : 1), req, "block reads", n_rd - rd0, hit ? 0 : 1);
    chk(n_wr - wr0 == (ewb ? 1 : 0), req, "block writes", n_wr - wr0, ewb ? 1 : 0);
    if (hit)
      chk(rsp_cyc == acc, "R3", "hit response cycle", rsp_cyc, acc);
    else
      chk(rd_addr == {a[11:2], 2'b00}, "R2", "fill address", int'(rd_addr), int'({a[11:2], 2'b00}));
    if (ewb) begin
      chk(wb_addr == vict, "R7", "victim address", int'(wb_addr), int'(vict));
      chk(wr_cyc < rd_cyc, "R7", "write-back before fill", wr_cyc, rd_cyc);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R1", "ready after reset", cpu_req_ready, 1);
    chk(mem_req_valid == 1'b0, "R1", "no memory request", mem_req_valid, 0);
    chk(cpu_rsp_valid == 1'b0, "R1", "no response", cpu_rsp_valid, 0);
    // R1/R5: cold cache, load misses
    access(0, 12'hFE2, 8'h00, "R5");
    // R3: hits on the same block, other offsets
    access(0, 12'hFE3, 8'h00, "R3");
    access(0, 12'hFE0, 8'h00, "R3");
    // R6: store miss allocates, then R4 follow-up hit
    access(1, 12'h61C, 8'hA7, "R6");
    access(0, 12'h61C, 8'h00, "R4");
    access(1, 12'h61E, 8'h3C, "R4");
    access(0, 12'h61F, 8'h00, "R4");
    access(0, 12'h61B, 8'h00, "R5");
    // R7: dirty victim written back before refill
    access(0, 12'hCAD, 8'h00, "R7");
    // R10: clean conflict, then the written-back data comes back
    access(0, 12'h61C, 8'h00, "R10");
    access(0, 12'h61E, 8'h00, "R10");
    // R4: store hits to entry 0, then R10 dirty conflict on it
    access(1, 12'hFE1, 8'h11, "R4");
    access(1, 12'hFE3, 8'h33, "R4");
    access(0, 12'hFE1, 8'h00, "R4");
    access(0, 12'h0E0, 8'h00, "R10");
    access(0, 12'hFE3, 8'h00, "R10");
    // R6: store miss over a dirty victim
    access(1, 12'h614, 8'h5D, "R6");
    access(1, 12'h3A4, 8'hE2, "R6");
    access(0, 12'h614, 8'h00, "R7");
    // Mixed pattern over a few tags sharing entries
    for (int i = 0; i < 48; i++) begin
      logic [11:0] a;
      a = {4'(i % 3), 4'(i * 5), 2'(i >> 1), 2'(i)};
      access(i % 4 == 1, a, 8'(i * 29 + 7), (i % 4 == 1) ? "R6" : "R5");
    end
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R9", "responses outstanding", expq.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      errs++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule